// File: doc/BRIEF.md
# Shift-Register Nibble Match Gate

This block is a programmable 4-input match gate. Its storage is a chain of sixteen one-bit flip-flops. A 4-bit select input picks which stored bit drives the output. When the chain holds a single one at the address equal to a target nibble, the output acts as an equality detector: the live data nibble is applied to the select lines, and the output goes high only for that value.

A built-in load sequencer programs the target. A start pulse in the idle state captures the target nibble. A 4-bit down-counter then runs from 15 to 0, producing one shift per cycle. A comparator feeds a one into the chain only on the cycle where the counter equals the target, so after sixteen shifts the single one sits at the target address.

The sequencer has three states:
- `ST_IDLE` (waiting): goes to `ST_LOAD` on `load_start`.
- `ST_LOAD` (shifting): stays in `ST_LOAD` while the counter is above zero, and goes to `ST_DONE` when the counter reaches zero.
- `ST_DONE` (one-cycle completion pulse): goes back to `ST_LOAD` if `load_start` is high, or to `ST_IDLE` if it is not.

Top module: `nibble_match_gate`

## Requirements
- R1: After reset the stored chain is all zero, and `match`, `load_busy` and `load_done` are low for every `data_nib` value.
- R2: `load_start` sampled high in `ST_IDLE` or `ST_DONE` captures `load_value`. `load_busy` is then high for exactly the next 16 cycles, one shift per cycle.
- R3: After a load of value V (including the extremes 0 and 15), `match` is 1 exactly when `data_nib` equals V. This is because the chain holds a single one, at bit address V.
- R4: `match` is held low in every cycle in which `load_busy` is high.
- R5: `load_done` is high for exactly one cycle, the cycle right after the 16th shift, and `load_busy` is low in that cycle.
- R6: `load_start` or a change of `load_value` while `load_busy` is high has no effect. The load in progress keeps its timing and its captured target.
- R7: Outside loading the chain holds its contents, and `data_nib` never alters the stored pattern, however long it is driven.
- R8: A new load fully replaces the previous pattern: the old target no longer matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_start | input | 1 | Request to program a new target |
| load_value | input | 4 | Target nibble captured on an accepted start |
| data_nib | input | 4 | Live data nibble, drives the select lines |
| match | output | 1 | High when `data_nib` equals the stored target and no load is in progress |
| load_busy | output | 1 | High during the 16 shift cycles |
| load_done | output | 1 | One-cycle pulse after the last shift |

## Verification
The assertions check these properties on every cycle:
- the chain holds whenever shifting is off;
- `match` stays low while loading;
- `load_busy` rises after an accepted start, and the counter steps down by one per busy cycle regardless of `load_start`;
- `load_done` follows the zero-count shift and lasts one cycle;
- the chain is exactly one-hot when loading completes.

Only the bench's scenarios can show that the one lands at the right address. The bench does this by sweeping all sixteen data nibbles after loads of 0, 15 and middle values. The same sweeps show that a reload erases the old target, that a start issued mid-load is dropped, and that long idle stretches with changing data leave the result unchanged.

// File: rtl/nm_pkg.sv
package nm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_DONE = 2'd2
    } nm_state_e;
endpackage

// File: rtl/nm_shift_lut.sv
module nm_shift_lut #(
    parameter int SEL_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    shift_en,
    input  logic                    ser_in,
    input  logic [SEL_W-1:0]        sel,
    output logic                    q_out,
    output logic [(1<<SEL_W)-1:0]   bits_o
);
    localparam int DEPTH = 1 << SEL_W;

    logic [DEPTH-1:0] bits;

    // Each cell takes its lower neighbour; cell 0 takes the serial input.
    // The top cell's old value falls off the end.
    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        logic nxt;
        if (i == 0) begin : g_head
            assign nxt = ser_in;
        end else begin : g_body
            assign nxt = bits[i-1];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        bits[i] <= 1'b0;
            else if (shift_en) bits[i] <= nxt;
        end
    end

    // The select lines only address the read port; they play no part in shifting.
    assign q_out  = bits[sel];
    assign bits_o = bits;

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(bits));
endmodule

// File: rtl/nm_load_seq.sv
module nm_load_seq
    import nm_pkg::*;
#(
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_start,
    input  logic [SEL_W-1:0] load_value,
    output logic             shift_en,
    output logic             ser_bit,
    output logic             busy,
    output logic             done
);
    localparam logic [SEL_W-1:0] CNT_TOP = {SEL_W{1'b1}};

    nm_state_e        state;
    logic [SEL_W-1:0] cnt;
    logic [SEL_W-1:0] tgt;
    logic             cnt_zero;

    assign cnt_zero = (cnt == '0);

    // State register, counter and captured target.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            tgt   <= '0;
        end else begin
            unique case (state)
                ST_IDLE, ST_DONE: begin
                    if (load_start) begin
                        state <= ST_LOAD;
                        cnt   <= CNT_TOP;
                        tgt   <= load_value;
                    end else begin
                        state <= ST_IDLE;
                    end
                end
                ST_LOAD: begin
                    cnt <= cnt - 1'b1;
                    if (cnt_zero) state <= ST_DONE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Outputs decoded from the state. The comparator feeds a one into the
    // chain only on the cycle where the counter equals the target.
    always_comb begin
        shift_en = 1'b0;
        ser_bit  = 1'b0;
        busy     = 1'b0;
        done     = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_LOAD: begin
                shift_en = 1'b1;
                busy     = 1'b1;
                ser_bit  = (cnt == tgt);
            end
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end

    // R2
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && load_start) |=> busy);

    // R6
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !cnt_zero) |=> (busy && cnt == $past(cnt) - 1'b1));

    // R5
    done_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt_zero) |=> (done && !busy));

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/nibble_match_gate.sv
module nibble_match_gate #(
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_start,
    input  logic [SEL_W-1:0] load_value,
    input  logic [SEL_W-1:0] data_nib,
    output logic             match,
    output logic             load_busy,
    output logic             load_done
);
    localparam int DEPTH = 1 << SEL_W;

    logic             shift_en;
    logic             ser_bit;
    logic             lut_q;
    logic [DEPTH-1:0] pattern;

    nm_load_seq #(.SEL_W(SEL_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_start (load_start),
        .load_value (load_value),
        .shift_en   (shift_en),
        .ser_bit    (ser_bit),
        .busy       (load_busy),
        .done       (load_done)
    );

    nm_shift_lut #(.SEL_W(SEL_W)) u_lut (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .ser_in   (ser_bit),
        .sel      (data_nib),
        .q_out    (lut_q),
        .bits_o   (pattern)
    );

    // A partly shifted pattern is meaningless, so the output is gated while loading.
    assign match = lut_q & ~load_busy;

    // R4
    quiet_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_busy |-> !match);

    // R3
    onehot_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |-> ($countones(pattern) == 1));
endmodule

// File: tb/tb_nibble_match_gate.sv
module tb_nibble_match_gate;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load_start = 1'b0;
    logic [3:0] load_value = '0;
    logic [3:0] data_nib = '0;
    logic       match, load_busy, load_done;

    int total = 0;
    int bad = 0;

    nibble_match_gate dut (
        .clk(clk), .rst_n(rst_n), .load_start(load_start),
        .load_value(load_value), .data_nib(data_nib),
        .match(match), .load_busy(load_busy), .load_done(load_done)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Sweep all nibbles; expect a hit only at v (v<0 means no hit anywhere).
    task automatic sweep(input int v, input string tag);
        for (int n = 0; n < 16; n++) begin
            @(negedge clk);
            data_nib = 4'(n);
            #1;
            chk(match == (n == v), tag, int'(match), int'(n == v));
        end
    endtask

    // Load v; optionally fire a stray start with value other mid-load (R6).
    task automatic do_load(input int v, input bit stray, input int other);
        @(negedge clk);
        load_start = 1'b1;
        load_value = 4'(v);
        @(negedge clk);
        load_start = 1'b0;
        load_value = 4'(other);
        data_nib = 4'(v);
        chk(load_busy == 1'b1, "R2 busy after start", int'(load_busy), 1);
        for (int i = 1; i < 16; i++) begin
            if (stray && i == 6) load_start = 1'b1;
            @(negedge clk);
            load_start = 1'b0;
            chk(load_busy == 1'b1, stray ? "R6 busy kept" : "R2 busy held", int'(load_busy), 1);
            chk(match == 1'b0, "R4 match forced low", int'(match), 0);
        end
        @(negedge clk);
        chk(load_done == 1'b1 && load_busy == 1'b0, "R5 done after 16th shift",
            int'({load_done, load_busy}), 2);
        @(negedge clk);
        chk(load_done == 1'b0, "R5 done one cycle", int'(load_done), 0);
    endtask

    task automatic t_reset();
        chk(load_busy == 1'b0 && load_done == 1'b0, "R1 reset flags",
            int'({load_busy, load_done}), 0);
        sweep(-1, "R1 reset match");
    endtask

    task automatic t_basic();
        do_load(5, 1'b0, 0);
        sweep(5, "R3 match value 5");
    endtask

    task automatic t_edges();
        do_load(0, 1'b0, 9);
        sweep(0, "R3 match value 0");
        do_load(15, 1'b0, 3);
        sweep(15, "R3 match value 15");
    endtask

    task automatic t_reload();
        do_load(10, 1'b0, 0);
        do_load(3, 1'b0, 10);
        sweep(3, "R8 reload replaces");
    endtask

    task automatic t_stray_start();
        do_load(7, 1'b1, 12);
        sweep(7, "R6 stray start ignored");
    endtask

    task automatic t_hold();
        do_load(9, 1'b0, 1);
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            data_nib = 4'(i * 7);
        end
        chk(load_busy == 1'b0, "R7 idle stays idle", int'(load_busy), 0);
        sweep(9, "R7 contents hold");
    endtask

    initial begin
        #(200000 * 20);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_edges();
        t_reload();
        t_stray_start();
        t_hold();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule